// File: doc/BRIEF.md
# SMM Context Save/Restore Sequencer

This block moves a small 32-bit core into and out of system management mode. A management interrupt can arrive at any time. The block takes it only when the core reports an instruction boundary. It then drives an active-low mode indicator and, one cycle later, starts walking a fixed table of 29 register images. Each image is written as one word to a memory port. The address of each word is a relocatable base, plus a fixed area offset, plus a per-image offset.

When a resume request arrives, the same table is walked again, this time as reads. Only the images marked as restorable are handed back to the core through a one-cycle restore strobe, together with an image index and the data. Read-only images are read but then dropped.

The core's register contents come in on a flat snapshot bus: image `i` sits in bits `[32*i+31 : 32*i]`. The base starts at 30000h. It can be replaced through a relocation load, but only while the block is idle.

Top module: `smm_ctx_seq`

## Requirements
- R1: An interrupt (a `smi_req` pulse, latched) is taken only in a cycle where `insn_bdry` is high and the block is idle. `smm_act_n` goes low in the next cycle, while `mem_req` is still low. The first write request follows one cycle later.
- R2: Each save address is base + 8000h + offset. Image indices 0 to 21 use offsets that step down by 4 from 7FFCh, in this order: CR0, CR3, EFLAGS, EIP, EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX, DR6, DR7, TR, LDTR, GS, FS, DS, SS, CS, ES. Indices 22 to 28 use 7F94h (IDT base), 7F88h (GDT base), 7F04h (I/O trap word), 7F02h (halt restart), 7F00h (I/O trap restart), 7EFCh (revision) and 7EF8h (dump base).
- R3: After reset the base is 30000h, so the first save write goes to 3FFFCh.
- R4: While idle, `reloc_en` loads `base_in` as the new base, and every later address moves with it. Outside idle, `reloc_en` is ignored.
- R5: Indices 14 to 21, 25 and 26 are half-word images. They are written with `mem_be` = 0011b and upper data half zero, so the upper two memory bytes keep their old contents. All other images use `mem_be` = 1111b.
- R6: Only one request is in flight at a time. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`, and the next image is presented only after the ack.
- R7: On `rsm_req` in system management mode, the 29 addresses are read (`mem_we` low) in the same order as the save.
- R8: Only indices 2 to 11, 25, 26 and 28 raise `rst_valid`, in the cycle after their read ack. `rst_sel` is the index and `rst_data` is the read word; half-word images are zero-extended from the low 16 bits. A restore therefore yields 13 strobes.
- R9: `save_done` pulses in the cycle after the ack of the last save write. `restore_done` pulses in the cycle after the ack of the last read. `smm_act_n` returns high one cycle after `restore_done`.
- R10: A `smi_req` that arrives during a save, in system management mode or during a restore is held pending and taken after exit, at the next boundary. `rsm_req` is ignored while idle.
- R11: In reset, `smm_act_n` is high, and `mem_req`, `save_done`, `restore_done` and `rst_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req | input | 1 | Management interrupt request pulse |
| insn_bdry | input | 1 | Core is at an instruction boundary |
| rsm_req | input | 1 | Resume request |
| ctx_snap | input | 928 | Flat register snapshot, 32 bits per image |
| base_in | input | 32 | Relocation base value |
| reloc_en | input | 1 | Load `base_in` as the base (idle only) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data |
| rst_valid | output | 1 | Restored image strobe |
| rst_sel | output | 5 | Index of the restored image |
| rst_data | output | 32 | Restored image value |
| save_done | output | 1 | Save finished pulse |
| restore_done | output | 1 | Restore finished pulse |
| smm_act_n | output | 1 | Active-low management mode indicator |

## Verification
The bench uses the default parameters: a reset base of 30000h and an area offset of 8000h. The first round therefore reaches the fixed reset address 3FFFCh. Later rounds relocate to random 32-bit bases, which exercises the address arithmetic across the whole range, including wraparound. A memory model acknowledges after random delays of zero to two cycles, which exposes request holding. A handler model rewrites every image between save and resume, which shows restore masking and half-word extension. The two half-word fields at 7F00h and 7F02h share one aligned word, which checks that their byte enables do not overlap.

// File: rtl/smm_ctx_pkg.sv
package smm_ctx_pkg;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int HALF_W     = WORD_W / 2;
  localparam int NUM_ENT    = 29;
  localparam int IDX_W      = $clog2(NUM_ENT);
  localparam int LAST_IDX   = NUM_ENT - 1;
  localparam int LINEAR_CNT = 22;
  localparam int STEP       = 4;
  localparam logic [15:0] LINEAR_TOP = 16'h7FFC;
  localparam int SEG_FIRST  = 14;
  localparam int SEG_LAST   = 21;
  localparam int HALT_IDX   = 25;
  localparam int IORST_IDX  = 26;
  localparam int DUMP_IDX   = 28;
  localparam int GPR_FIRST  = 2;
  localparam int GPR_LAST   = 11;

  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_SAVE, ST_INSMM, ST_RESTORE, ST_EXIT
  } seq_st_t;

  // Offset of image i inside the save area.
  function automatic logic [15:0] ent_offset(idx_t i);
    logic [15:0] o;
    if (int'(i) < LINEAR_CNT) begin
      o = LINEAR_TOP - 16'(int'(i) * STEP);
    end else begin
      case (int'(i) - LINEAR_CNT)
        0:       o = 16'h7F94;
        1:       o = 16'h7F88;
        2:       o = 16'h7F04;
        3:       o = 16'h7F02;
        4:       o = 16'h7F00;
        5:       o = 16'h7EFC;
        default: o = 16'h7EF8;
      endcase
    end
    return o;
  endfunction

  // Image occupies only the low half of its word.
  function automatic logic ent_half(idx_t i);
    return ((int'(i) >= SEG_FIRST) && (int'(i) <= SEG_LAST)) ||
           (int'(i) == HALT_IDX) || (int'(i) == IORST_IDX);
  endfunction

  // Image is returned to the core on resume.
  function automatic logic ent_wr(idx_t i);
    return ((int'(i) >= GPR_FIRST) && (int'(i) <= GPR_LAST)) ||
           (int'(i) == HALT_IDX) || (int'(i) == IORST_IDX) ||
           (int'(i) == DUMP_IDX);
  endfunction

  function automatic logic [ADDR_W-1:0] ent_addr(logic [ADDR_W-1:0] base,
                                                 logic [ADDR_W-1:0] area,
                                                 idx_t i);
    return base + area + ADDR_W'(ent_offset(i));
  endfunction
endpackage

// File: rtl/smm_smi_latch.sv
module smm_smi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic smi_req,
  input  logic take,
  output logic pend
);
  logic pend_q;

  assign pend = pend_q | smi_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (take) pend_q <= 1'b0;
    else           pend_q <= pend;
  end
endmodule

// File: rtl/smm_base_reg.sv
module smm_base_reg #(
  parameter int          AW         = 32,
  parameter logic [AW-1:0] RESET_BASE = 32'h0003_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= RESET_BASE;
    else if (load) base_q <= base_in;
  end
endmodule

// File: rtl/smm_walker.sv
module smm_walker
  import smm_ctx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take_i,
  input  logic    rsm_i,
  input  logic    ack_i,
  output seq_st_t st_o,
  output idx_t    idx_o,
  output logic    act_n_o,
  output logic    save_done_o,
  output logic    restore_done_o
);
  seq_st_t st_q, st_d;
  idx_t    idx_q, idx_d;
  logic    last;

  assign last  = (idx_q == idx_t'(LAST_IDX));
  assign st_o  = st_q;
  assign idx_o = idx_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_IDLE:  if (take_i) st_d = ST_ENTER;
      ST_ENTER: begin
        st_d  = ST_SAVE;
        idx_d = '0;
      end
      ST_SAVE: if (ack_i) begin
        if (last) st_d = ST_INSMM;
        else      idx_d = idx_q + 1'b1;
      end
      ST_INSMM: if (rsm_i) begin
        st_d  = ST_RESTORE;
        idx_d = '0;
      end
      ST_RESTORE: if (ack_i) begin
        if (last) st_d = ST_EXIT;
        else      idx_d = idx_q + 1'b1;
      end
      ST_EXIT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      idx_q          <= '0;
      act_n_o        <= 1'b1;
      save_done_o    <= 1'b0;
      restore_done_o <= 1'b0;
    end else begin
      st_q           <= st_d;
      idx_q          <= idx_d;
      save_done_o    <= (st_q == ST_SAVE) && ack_i && last;
      restore_done_o <= (st_q == ST_RESTORE) && ack_i && last;
      if ((st_q == ST_IDLE) && take_i) act_n_o <= 1'b0;
      else if (st_q == ST_EXIT)        act_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/smm_ctx_seq.sv
module smm_ctx_seq
  import smm_ctx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] AREA_OFS   = 32'h0000_8000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smi_req,
  input  logic                      insn_bdry,
  input  logic                      rsm_req,
  input  logic [NUM_ENT*WORD_W-1:0] ctx_snap,
  input  logic [ADDR_W-1:0]         base_in,
  input  logic                      reloc_en,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [WORD_W-1:0]         mem_wdata,
  output logic [BE_W-1:0]           mem_be,
  input  logic                      mem_ack,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic                      rst_valid,
  output logic [IDX_W-1:0]          rst_sel,
  output logic [WORD_W-1:0]         rst_data,
  output logic                      save_done,
  output logic                      restore_done,
  output logic                      smm_act_n
);
  // Named internal events, visible to the bound checker.
  seq_st_t           st_w;
  idx_t              idx_w;
  logic              pend_w;
  logic              take_ev;
  logic              idle_w;
  logic              rd_ack_ev;
  logic              half_w;
  logic [ADDR_W-1:0] base_w;
  logic [WORD_W-1:0] cur_word;
  logic [WORD_W-1:0] snap_arr [NUM_ENT];

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_unpack
      assign snap_arr[g] = ctx_snap[g*WORD_W +: WORD_W];
    end
  endgenerate

  assign idle_w    = (st_w == ST_IDLE);
  assign take_ev   = idle_w && pend_w && insn_bdry;
  assign rd_ack_ev = (st_w == ST_RESTORE) && mem_ack;
  assign half_w    = ent_half(idx_w);
  assign cur_word  = (int'(idx_w) <= LAST_IDX) ? snap_arr[idx_w] : '0;

  smm_smi_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .smi_req (smi_req),
    .take    (take_ev),
    .pend    (pend_w)
  );

  smm_base_reg #(.AW(ADDR_W), .RESET_BASE(RESET_BASE)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (reloc_en && idle_w),
    .base_in (base_in),
    .base_q  (base_w)
  );

  smm_walker u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .take_i         (take_ev),
    .rsm_i          (rsm_req),
    .ack_i          (mem_ack),
    .st_o           (st_w),
    .idx_o          (idx_w),
    .act_n_o        (smm_act_n),
    .save_done_o    (save_done),
    .restore_done_o (restore_done)
  );

  assign mem_req   = (st_w == ST_SAVE) || (st_w == ST_RESTORE);
  assign mem_we    = (st_w == ST_SAVE);
  assign mem_addr  = ent_addr(base_w, AREA_OFS, idx_w);
  assign mem_wdata = half_w ? WORD_W'(cur_word[HALF_W-1:0]) : cur_word;
  assign mem_be    = half_w ? BE_W'({(BE_W/2){1'b1}}) : {BE_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_valid <= 1'b0;
      rst_sel   <= '0;
      rst_data  <= '0;
    end else begin
      rst_valid <= 1'b0;
      if (rd_ack_ev && ent_wr(idx_w)) begin
        rst_valid <= 1'b1;
        rst_sel   <= idx_w;
        rst_data  <= half_w ? WORD_W'(mem_rdata[HALF_W-1:0]) : mem_rdata;
      end
    end
  end
endmodule

// File: rtl/smm_ctx_chk.sv
module smm_ctx_chk
  import smm_ctx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              insn_bdry,
  input logic              smm_act_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BE_W-1:0]   mem_be,
  input logic              rst_valid,
  input logic              save_done,
  input logic              restore_done,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [ADDR_W-1:0] base_q
);
  logic [ADDR_W-1:0] rel_addr;
  assign rel_addr = mem_addr - base_q;

  p_req_in_smm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !smm_act_n);
  p_enter_on_bdry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smm_act_n) |-> $past(insn_bdry));
  p_enter_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smm_act_n) |-> !mem_req);
  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (rel_addr >= 32'h0000_FEF8) && (rel_addr <= 32'h0000_FFFC));
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(cur_idx) < NUM_ENT));
  p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'b1111) || (mem_be == 4'b0011));
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_restore_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_valid |-> $past(mem_ack && mem_req && !mem_we));
  p_exit_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_done |=> smm_act_n);
  p_done_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(save_done && restore_done));
endmodule

bind smm_ctx_seq smm_ctx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_bdry    (insn_bdry),
  .smm_act_n    (smm_act_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be),
  .rst_valid    (rst_valid),
  .save_done    (save_done),
  .restore_done (restore_done),
  .cur_idx      (idx_w),
  .base_q       (base_w)
);

// File: tb/sim_smm_ctx_seq.sv
module sim_smm_ctx_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NE         = 29;
  localparam int WD_CYCLES  = 100000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           smi_req, insn_bdry, rsm_req, reloc_en;
  logic [NE*32-1:0] snap;
  logic [31:0]    base_in;
  logic           mem_req, mem_we, mem_ack;
  logic [31:0]    mem_addr, mem_wdata, mem_rdata;
  logic [3:0]     mem_be;
  logic           rst_valid, save_done, restore_done, smm_act_n;
  logic [4:0]     rst_sel;
  logic [31:0]    rst_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_ctx_seq u0 (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .insn_bdry(insn_bdry),
    .rsm_req(rsm_req), .ctx_snap(snap), .base_in(base_in), .reloc_en(reloc_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rst_valid(rst_valid), .rst_sel(rst_sel),
    .rst_data(rst_data), .save_done(save_done), .restore_done(restore_done),
    .smm_act_n(smm_act_n)
  );

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_base = 32'h0003_0000;
  logic [31:0] exp_rd [NE];
  logic [7:0]  mem [logic [31:0]];
  int wr_k, rd_k, rst_cnt;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  function automatic logic [31:0] tb_off(int k);
    logic [15:0] tail [7] = '{16'h7F94, 16'h7F88, 16'h7F04, 16'h7F02,
                              16'h7F00, 16'h7EFC, 16'h7EF8};
    if (k < 22) return 32'h7FFC - 32'(k << 2);
    return {16'h0, tail[k-22]};
  endfunction

  function automatic logic [31:0] tb_addr(int k);
    return exp_base + 32'h8000 + tb_off(k);
  endfunction

  function automatic bit tb_half(int k);
    return (k >= 14 && k <= 21) || k == 25 || k == 26;
  endfunction

  function automatic bit tb_wr(int k);
    return (k >= 2 && k <= 11) || k == 25 || k == 26 || k == 28;
  endfunction

  function automatic logic [7:0] rd_byte(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return {rd_byte(a+3), rd_byte(a+2), rd_byte(a+1), rd_byte(a)};
  endfunction

  // Memory model with random ack latency and per-request checks.
  initial begin : responder
    bit in_req = 0;
    int dly = 0;
    bit last_we = 0;
    int last_k = 0;
    logic [31:0] hold_addr = '0;
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0;
        in_req = 0;
      end else if (mem_ack) begin
        mem_ack = 1'b0;
        if (last_we) begin
          check(save_done == (last_k == NE-1), "R9 save_done timing",
                32'(save_done), 32'(last_k == NE-1));
        end else begin
          check(restore_done == (last_k == NE-1), "R9 restore_done timing",
                32'(restore_done), 32'(last_k == NE-1));
          check(rst_valid == tb_wr(last_k), "R8 restore mask",
                32'(rst_valid), 32'(tb_wr(last_k)));
          if (rst_valid) begin
            rst_cnt++;
            check(rst_sel == 5'(last_k), "R8 restore index", 32'(rst_sel), 32'(last_k));
            check(rst_data == exp_rd[last_k], "R8 restore data", rst_data, exp_rd[last_k]);
          end
        end
      end else if (mem_req) begin
        if (!in_req) begin
          in_req = 1;
          hold_addr = mem_addr;
          dly = int'($urandom % 3);
        end else begin
          check(mem_addr == hold_addr, "R6 request held", mem_addr, hold_addr);
        end
        if (dly == 0) begin
          int k;
          if (mem_we) begin
            logic [31:0] sw;
            logic [31:0] ew;
            k = wr_k;
            sw = snap[k*32 +: 32];
            ew = tb_half(k) ? {16'h0, sw[15:0]} : sw;
            check(mem_addr == tb_addr(k), "R2 save address", mem_addr, tb_addr(k));
            check(mem_be == (tb_half(k) ? 4'b0011 : 4'b1111), "R5 byte enables",
                  32'(mem_be), 32'(tb_half(k) ? 4'b0011 : 4'b1111));
            check(mem_wdata == ew, "R5 write data", mem_wdata, ew);
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr + 32'(b)] = mem_wdata[b*8 +: 8];
            wr_k++;
          end else begin
            k = rd_k;
            check(mem_addr == tb_addr(k), "R7 restore address", mem_addr, tb_addr(k));
            mem_rdata = rd_word(mem_addr);
            rd_k++;
          end
          mem_ack = 1'b1;
          in_req = 0;
          last_we = mem_we;
          last_k = k;
        end else begin
          dly--;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL R9 watchdog actual=hung expected=completion");
    finish_run();
  end

  task automatic run_round(bit reloc, logic [31:0] nb, bit smi_mid, bit pulse,
                           string first_tag);
    wr_k = 0;
    rd_k = 0;
    rst_cnt = 0;
    if (reloc) begin
      reloc_en = 1'b1;
      base_in = nb;
      @(negedge clk);
      reloc_en = 1'b0;
      exp_base = nb;
    end
    for (int k = 0; k < NE; k++) snap[k*32 +: 32] = $urandom;
    for (int k = 14; k <= 21; k++) begin
      mem[tb_addr(k) + 2] = 8'hA5;
      mem[tb_addr(k) + 3] = 8'hA5;
    end
    // no entry without a boundary
    smi_req = pulse;
    insn_bdry = 1'b0;
    @(negedge clk);
    smi_req = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(smm_act_n == 1'b1, "R1 waits for boundary", 32'(smm_act_n), 32'd1);
    end
    insn_bdry = 1'b1;
    @(negedge clk);
    insn_bdry = 1'b0;
    check(!smm_act_n && !mem_req, {first_tag, " act low before request"},
          {30'd0, smm_act_n, mem_req}, 32'd0);
    @(negedge clk);
    check(mem_req && mem_we, "R1 first write issued", 32'(mem_req && mem_we), 32'd1);
    check(mem_addr == exp_base + 32'hFFFC, {first_tag, " first save address"},
          mem_addr, exp_base + 32'hFFFC);
    if (smi_mid) begin
      smi_req = 1'b1;
      @(negedge clk);
      smi_req = 1'b0;
    end
    while (wr_k < NE || mem_ack) @(negedge clk);
    repeat (2) @(negedge clk);
    check(!smm_act_n && !mem_req, "R9 idle in mode after save",
          {30'd0, smm_act_n, mem_req}, 32'd0);
    for (int k = 14; k <= 21; k++)
      check(rd_word(tb_addr(k)) >> 16 == 32'h0000_A5A5, "R5 upper bytes kept",
            rd_word(tb_addr(k)) >> 16, 32'h0000_A5A5);
    // relocation attempt while in mode must be ignored
    reloc_en = 1'b1;
    base_in = ~exp_base;
    @(negedge clk);
    reloc_en = 1'b0;
    // handler rewrites images
    for (int k = 0; k < NE; k++) begin
      logic [31:0] w = $urandom;
      logic [31:0] a = tb_addr(k);
      for (int b = 0; b < (tb_half(k) ? 2 : 4); b++) mem[a + 32'(b)] = w[b*8 +: 8];
      exp_rd[k] = tb_half(k) ? {16'h0, w[15:0]} : w;
    end
    rsm_req = 1'b1;
    @(negedge clk);
    rsm_req = 1'b0;
    check(mem_req && !mem_we && mem_addr == exp_base + 32'hFFFC,
          "R4 base frozen while busy", mem_addr, exp_base + 32'hFFFC);
    while (!restore_done) @(negedge clk);
    @(negedge clk);
    check(smm_act_n == 1'b1, "R9 act high after restore_done", 32'(smm_act_n), 32'd1);
    check(rst_cnt == 13, "R8 restore strobe count", 32'(rst_cnt), 32'd13);
    if (smi_mid) begin
      @(negedge clk);
      check(smm_act_n == 1'b1, "R10 pending holds for boundary", 32'(smm_act_n), 32'd1);
    end
  endtask

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    smi_req = 1'b0;
    insn_bdry = 1'b0;
    rsm_req = 1'b0;
    reloc_en = 1'b0;
    base_in = '0;
    snap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(smm_act_n == 1'b1, "R11 reset act_n", 32'(smm_act_n), 32'd1);
    check(!mem_req && !save_done && !restore_done && !rst_valid, "R11 reset outputs",
          {28'd0, mem_req, save_done, restore_done, rst_valid}, 32'd0);
    rsm_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!mem_req && smm_act_n, "R10 resume ignored when idle",
            {30'd0, mem_req, smm_act_n}, 32'd1);
    end
    rsm_req = 1'b0;
    run_round(1'b0, 32'h0, 1'b1, 1'b1, "R3");
    run_round(1'b1, $urandom, 1'b0, 1'b0, "R10");
    for (int r = 0; r < 4; r++) run_round(1'b1, $urandom, 1'b0, 1'b1, "R4");
    finish_run();
  end
endmodule